// File: doc/BRIEF.md
# Relative and Absolute Time Snapshot Unit

This block runs a free-running relative time count that advances by one on every cycle where a 10 MHz clock enable is high. The count is 48 bits wide by default. A periodic strobe, nominally once per millisecond, takes a snapshot of that count and, in the same clock cycle, of an absolute time value presented on an input bus. Each pair goes into a small show-ahead FIFO. Packet builders drain it, placing the relative value in every packet header and both values in time packets.

A marker input travels with each capture. It tags the snapshots taken on a one-second boundary, which are the ones a time packet builder uses. With a 10 MHz enable and strobes on exact one-second ticks, the tagged relative values fall on multiples of 10,000,000. If the FIFO is full when a strobe arrives and nothing is read in that cycle, the capture is discarded and a sticky overflow flag rises. The flag clears only on reset.

Top module: `time_snap_unit`

## Requirements
- R1: A synchronous active-high reset sets the relative count to 0, empties the FIFO (`snap_valid` = 0) and clears `overflow`.
- R2: The relative count, visible on `rel_now`, rises by exactly one after each clock edge where `tick_en` is 1, and holds where `tick_en` is 0.
- R3: When the count is all ones and `tick_en` is 1, the count becomes 0 on the next edge, with no flag raised.
- R4: A strobe captures the `rel_now` value seen in the strobe cycle, which is the value before that cycle's increment, even when `tick_en` is also 1.
- R5: The `abs_time` value present in the strobe cycle is stored in the same FIFO entry as the relative value of R4.
- R6: Entries leave the FIFO in arrival order. The head entry appears on the `snap_*` outputs while `snap_valid` is 1. A cycle with `snap_take` = 1 and `snap_valid` = 1 removes the head.
- R7: A strobe that arrives while the FIFO holds DEPTH entries, with no removal in that cycle, is dropped and sets `overflow`. `overflow` stays at 1 until reset.
- R8: A strobe in a cycle where the FIFO is full and the head is removed is accepted, and it does not set `overflow`.
- R9: `snap_take` while the FIFO is empty has no effect. A later capture becomes the head.
- R10: The `sec_mark` level in the strobe cycle is stored with the entry and returned on `snap_sec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | 10 MHz count enable |
| strobe | input | 1 | Capture request, one per cycle held high |
| abs_time | input | ABS_W | Absolute time sampled on strobe |
| sec_mark | input | 1 | Marks the capture as a one-second boundary |
| snap_take | input | 1 | Removes the head entry |
| rel_now | output | CNT_W | Live relative count |
| snap_valid | output | 1 | FIFO holds at least one entry |
| snap_rel | output | CNT_W | Head entry relative count |
| snap_abs | output | ABS_W | Head entry absolute time |
| snap_sec | output | 1 | Head entry boundary marker |
| overflow | output | 1 | Sticky: a capture was dropped |

## Verification
Two situations are hard to reach from the ports: the counter wrap, and a strobe landing on a full FIFO in the same cycle as a removal. A 48-bit count never wraps in a practical run. The bench therefore instantiates an 8-bit counter and a four-entry FIFO, and sweeps gated enables long enough to pass through the wrap twice. It then stops reading so that strobes fill the FIFO, and drives a strobe together with a removal at full level. Both the dropped path and the accepted path are then observed while the FIFO is drained.

// File: rtl/time_snap_unit.sv
module time_snap_unit #(
  parameter int CNT_W = 48,
  parameter int ABS_W = 64,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             strobe,
  input  logic [ABS_W-1:0] abs_time,
  input  logic             sec_mark,
  input  logic             snap_take,
  output logic [CNT_W-1:0] rel_now,
  output logic             snap_valid,
  output logic [CNT_W-1:0] snap_rel,
  output logic [ABS_W-1:0] snap_abs,
  output logic             snap_sec,
  output logic             overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FULL_LVL = (PTR_W+1)'(DEPTH);
  localparam logic [PTR_W:0] FILL_ONE = (PTR_W+1)'(1);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   fill;
  logic [CNT_W-1:0] mem_rel [DEPTH];
  logic [ABS_W-1:0] mem_abs [DEPTH];
  logic             mem_sec [DEPTH];
  logic             full, pop, push;

  assign full = (fill == FULL_LVL);
  assign pop  = snap_take && (fill != '0);
  assign push = strobe && (!full || pop);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (tick_en) cnt <= cnt + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_ONE;
      if (pop)  rd_ptr <= rd_ptr + PTR_ONE;
      case ({push, pop})
        2'b10:   fill <= fill + FILL_ONE;
        2'b01:   fill <= fill - FILL_ONE;
        default: fill <= fill;
      endcase
      if (strobe && !push) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_rel[wr_ptr] <= cnt;
      mem_abs[wr_ptr] <= abs_time;
      mem_sec[wr_ptr] <= sec_mark;
    end
  end

  assign rel_now    = cnt;
  assign snap_valid = (fill != '0);
  assign snap_rel   = mem_rel[rd_ptr];
  assign snap_abs   = mem_abs[rd_ptr];
  assign snap_sec   = mem_sec[rd_ptr];

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> (rel_now == CNT_W'($past(rel_now) + CNT_ONE)));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(rel_now));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_drop_keeps_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe && full && !snap_take) |=> (fill == $past(fill)) && overflow);
  assert_full_swap_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe && full && snap_take && !overflow) |=> (fill == FULL_LVL) && !overflow);
  assert_empty_take_R9: assert property (@(posedge clk) disable iff (rst)
    (snap_take && !strobe && !snap_valid) |=> !snap_valid);
  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_LVL);
endmodule

// File: tb/tb_time_snap_unit.sv
module tb_time_snap_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int AW = 16;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, strobe = 1'b0, sec_mark = 1'b0, snap_take = 1'b0;
  logic [AW-1:0] abs_time = '0;
  logic [CW-1:0] rel_now, snap_rel;
  logic [AW-1:0] snap_abs;
  logic snap_valid, snap_sec, overflow;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [CW-1:0] m_cnt;
  int m_n;
  logic m_ovf;
  logic [CW-1:0] q_rel [DP];
  logic [AW-1:0] q_abs [DP];
  logic q_sec [DP];
  bit wrapped;

  time_snap_unit #(.CNT_W(CW), .ABS_W(AW), .DEPTH(DP)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .strobe(strobe),
    .abs_time(abs_time), .sec_mark(sec_mark), .snap_take(snap_take),
    .rel_now(rel_now), .snap_valid(snap_valid), .snap_rel(snap_rel),
    .snap_abs(snap_abs), .snap_sec(snap_sec), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(wrapped ? "R3 wrap" : "R2 count", 64'(rel_now), 64'(m_cnt));
    chk("R6 valid", 64'(snap_valid), 64'(m_n > 0));
    chk("R7 overflow", 64'(overflow), 64'(m_ovf));
    if (m_n > 0) begin
      chk("R4 rel", 64'(snap_rel), 64'(q_rel[0]));
      chk("R5 abs", 64'(snap_abs), 64'(q_abs[0]));
      chk("R10 sec", 64'(snap_sec), 64'(q_sec[0]));
    end
  endtask

  task automatic step(input logic te, input logic st, input logic sm,
                      input logic re, input logic [AW-1:0] ab);
    bit p, f, pu;
    tick_en = te; strobe = st; sec_mark = sm; snap_take = re; abs_time = ab;
    @(posedge clk);
    p = re && (m_n > 0);
    f = (m_n == DP);
    pu = st && (!f || p);
    if (st && !pu) m_ovf = 1'b1;
    if (p) begin
      for (int k = 0; k < DP-1; k++) begin
        q_rel[k] = q_rel[k+1]; q_abs[k] = q_abs[k+1]; q_sec[k] = q_sec[k+1];
      end
      m_n--;
    end
    if (pu) begin
      q_rel[m_n] = m_cnt; q_abs[m_n] = ab; q_sec[m_n] = sm; m_n++;
    end
    wrapped = te && (m_cnt == '1);
    if (te) m_cnt = m_cnt + 1'b1;
    @(negedge clk);
    compare_all();
    wrapped = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick_en = 0; strobe = 0; sec_mark = 0; snap_take = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = '0; m_n = 0; m_ovf = 0; wrapped = 0;
    chk("R1 count", 64'(rel_now), 64'd0);
    chk("R1 empty", 64'(snap_valid), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] last_abs;
    @(negedge clk);
    do_reset();

    // R2 R3 R4 R5 R6 R10: gated enable sweep through two wraps
    for (int i = 0; i < 800; i++) begin
      step((i % 3) != 0, (i % 7) == 3, ((i / 7) % 5) == 0, (i % 4) != 1,
           AW'(16'hA000 + i));
    end
    for (int i = 0; i < 300; i++) begin
      step(1'b1, (i % 5) == 0, (i % 10) == 0, (i % 2) == 0, AW'(16'h3000 + i));
    end

    // R7: fill without reading, then overflow
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, i[0], 1'b0, AW'(16'h5000 + i));
    chk("R7 dropped sets flag", 64'(overflow), 64'd1);
    step(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R7 flag sticky", 64'(overflow), 64'd1);

    // R8: strobe with removal while full
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, AW'(16'h6000 + i));
    step(1'b1, 1'b1, 1'b1, 1'b1, 16'h6EEE);
    chk("R8 no overflow", 64'(overflow), 64'd0);
    last_abs = '0;
    for (int i = 0; i < 4; i++) begin
      last_abs = snap_abs;
      step(1'b0, 1'b0, 1'b0, 1'b1, '0);
    end
    chk("R8 accepted entry last", 64'(last_abs), 64'h6EEE);

    // R9: removal on empty is ignored
    step(1'b1, 1'b0, 1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 1'b0, 1'b1, '0);
    chk("R9 still empty", 64'(snap_valid), 64'd0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 16'h7777);
    chk("R9 new head abs", 64'(snap_abs), 64'h7777);
    chk("R9 new head sec", 64'(snap_sec), 64'd1);

    do_reset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule